// File: doc/BRIEF.md
# Profile Enable Flag Memory

This block records, for each of up to 16 mixing profiles, which actuators and sensors are enabled. Every peripheral is named by three fields: the profile it belongs to, an item class (motor, vessel, general output, an unused "none" class, and four sensor classes), and a 5-bit index within that class. A sequencer sets an enable by presenting a single 12-bit operand with a write strobe, and each write sets exactly one bit. Bits are only cleared by reset.

Three registered read ports serve the rest of the controller. A general port returns the enable of any (profile, class, index). A sensor port takes a 2-bit sensor class and forms the class code by prefixing a 1, so only the four sensor classes can be reached through it. A class-wide port reports whether the "all" marker of a (profile, class) pair is set. Index 0 of every class is that marker: while it is set, every index of the class reads as enabled on the general and sensor ports.

Top module: `profile_flag_mem`

## Requirements
- R1: A write operand carries the index in bits [4:0], the item class in bits [7:5] and the profile in bits [11:8]; when `wr_en` is high at a rising clock edge, the bit named by those fields is set.
- R2: A write sets exactly one bit and leaves every other bit unchanged; a set bit stays set until reset.
- R3: A write whose item class is 3 (none) changes no bit.
- R4: `rd_bit` shows, one clock edge after sampling, the enable of (`rd_prof`, `rd_item`, `rd_idx`).
- R5: While index 0 of a (profile, class) pair is set, the general and sensor ports return 1 for every index of that class.
- R6: The sensor port reads class 4 + `sn_cls` (0 temperature, 1 pressure, 2 concentration, 3 general input) of profile `sn_prof`, with the same latency and index-0 rule as the general port.
- R7: `all_bit` shows, one clock edge after sampling, bit 0 of (`all_prof`, `all_item`).
- R8: Reset is synchronous and active low; a clock edge with `rst_n` low clears every bit and drives all three read outputs to 0.
- R9: A read sampled at the same edge as a write to the same bit returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 12 | Write operand {profile, class, index} |
| rd_prof | input | 4 | General read profile |
| rd_item | input | 3 | General read class |
| rd_idx | input | 5 | General read index |
| rd_bit | output | 1 | General read result |
| sn_prof | input | 4 | Sensor read profile |
| sn_cls | input | 2 | Sensor class (0..3 maps to classes 4..7) |
| sn_idx | input | 5 | Sensor read index |
| sn_bit | output | 1 | Sensor read result |
| all_prof | input | 4 | Class-wide query profile |
| all_item | input | 3 | Class-wide query class |
| all_bit | output | 1 | Class-wide "all" marker |

## Verification
Every read result is due exactly one rising edge after its address is sampled, and a write becomes visible to reads sampled at the following edge, not the same one. The bench keeps a behavioural model that, at each rising edge, computes the three expected outputs from its state before applying that edge's write, then updates the state. Inputs change and outputs are compared only at falling edges, so each comparison sees the results of the most recent rising edge against the values the model predicted for it.

// File: rtl/pfm_pkg.sv
// Shared item-class codes for the profile enable flag memory.
// Assumes a 3-bit class field; classes 4..7 are sensors.
package pfm_pkg;
    typedef enum logic [2:0] {
        IT_MOTOR  = 3'd0,
        IT_VESSEL = 3'd1,
        IT_GOUT   = 3'd2,
        IT_NONE   = 3'd3,
        IT_TEMP   = 3'd4,
        IT_PRESS  = 3'd5,
        IT_CONC   = 3'd6,
        IT_GIN    = 3'd7
    } item_e;

    localparam int ITEM_W = $bits(item_e);
endpackage

// File: rtl/pfm_store.sv
// Row-organised enable storage: one row per (profile, class), one bit
// per index. Writes set a single bit; class IT_NONE writes are dropped.
// Assumes the caller forms read row addresses; reads are combinational.
module pfm_store
    import pfm_pkg::*;
#(
    parameter int PROF_W = 4,
    parameter int IDX_W  = 5,
    parameter int NRD    = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [PROF_W-1:0]                      wr_prof,
    input  logic [ITEM_W-1:0]                      wr_item,
    input  logic [IDX_W-1:0]                       wr_idx,
    input  logic [NRD-1:0][PROF_W+ITEM_W-1:0]      rd_row_addr,
    output logic [NRD-1:0][(1<<IDX_W)-1:0]         rd_rows
);
    localparam int ROW_AW = PROF_W + ITEM_W;
    localparam int NROWS  = 1 << ROW_AW;
    localparam int NBITS  = 1 << IDX_W;

    logic [NBITS-1:0]  mem [NROWS];
    logic [ROW_AW-1:0] waddr;
    logic              wr_take;

    assign waddr   = {wr_prof, wr_item};
    assign wr_take = wr_en && (wr_item != IT_NONE);

    // Clear on reset, otherwise set the addressed bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NROWS; r++) begin
                mem[r] <= '0;
            end
        end else if (wr_take) begin
            mem[waddr][wr_idx] <= 1'b1;
        end
    end

    // One combinational row fetch per read port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_rows[g] = mem[rd_row_addr[g]];
    end

    AST_NONE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_item == IT_NONE) |=> mem[$past(waddr)] == $past(mem[waddr])); // R3

    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_item != IT_NONE) |=> mem[$past(waddr)][$past(wr_idx)]); // R1

    AST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $countones(mem[$past(waddr)] ^ $past(mem[waddr])) <= 1); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (mem[0] == '0 && mem[NROWS-1] == '0)); // R8
endmodule

// File: rtl/pfm_rdport.sv
// Registered single-bit read of one row, merging the row's index-0
// "all" marker. Tie idx to zero to read the marker alone.
module pfm_rdport #(
    parameter int IDX_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [(1<<IDX_W)-1:0]  row,
    input  logic [IDX_W-1:0]       idx,
    output logic                   bit_q
);
    // Register the addressed bit OR the class-wide marker.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= row[idx] | row[0];
    end

    AST_ALL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        row[0] |=> bit_q); // R5

    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!row[idx] && !row[0]) |=> !bit_q); // R4

    AST_RD_RESET: assert property (@(posedge clk)
        !rst_n |=> !bit_q); // R8
endmodule

// File: rtl/profile_flag_mem.sv
// Top of the profile enable flag memory: splits the write operand,
// forms three row addresses (general, sensor, class-wide) and drives
// three registered read ports from the shared storage.
// Assumes one write per cycle; reads see the state before that write.
module profile_flag_mem
    import pfm_pkg::*;
#(
    parameter int PROF_W = 4,
    parameter int IDX_W  = 5,
    parameter int SCLS_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [PROF_W+ITEM_W+IDX_W-1:0]    wr_op,
    input  logic [PROF_W-1:0]                 rd_prof,
    input  logic [ITEM_W-1:0]                 rd_item,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic                              rd_bit,
    input  logic [PROF_W-1:0]                 sn_prof,
    input  logic [SCLS_W-1:0]                 sn_cls,
    input  logic [IDX_W-1:0]                  sn_idx,
    output logic                              sn_bit,
    input  logic [PROF_W-1:0]                 all_prof,
    input  logic [ITEM_W-1:0]                 all_item,
    output logic                              all_bit
);
    localparam int ROW_AW = PROF_W + ITEM_W;
    localparam int NBITS  = 1 << IDX_W;
    localparam int NRD    = 3;

    logic [NRD-1:0][ROW_AW-1:0] row_addr;
    logic [NRD-1:0][NBITS-1:0]  rows;
    logic [PROF_W-1:0]          w_prof;
    logic [ITEM_W-1:0]          w_item;
    logic [IDX_W-1:0]           w_idx;

    // Operand fields: index low, class middle, profile high.
    assign w_idx  = wr_op[IDX_W-1:0];
    assign w_item = wr_op[IDX_W +: ITEM_W];
    assign w_prof = wr_op[IDX_W+ITEM_W +: PROF_W];

    // Row addresses; the sensor port forces the class MSB high.
    assign row_addr[0] = {rd_prof, rd_item};
    assign row_addr[1] = {sn_prof, 1'b1, sn_cls};
    assign row_addr[2] = {all_prof, all_item};

    pfm_store #(.PROF_W(PROF_W), .IDX_W(IDX_W), .NRD(NRD)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_prof     (w_prof),
        .wr_item     (w_item),
        .wr_idx      (w_idx),
        .rd_row_addr (row_addr),
        .rd_rows     (rows)
    );

    pfm_rdport #(.IDX_W(IDX_W)) u_rd_gen (
        .clk (clk), .rst_n (rst_n), .row (rows[0]), .idx (rd_idx), .bit_q (rd_bit)
    );

    pfm_rdport #(.IDX_W(IDX_W)) u_rd_sen (
        .clk (clk), .rst_n (rst_n), .row (rows[1]), .idx (sn_idx), .bit_q (sn_bit)
    );

    pfm_rdport #(.IDX_W(IDX_W)) u_rd_all (
        .clk (clk), .rst_n (rst_n), .row (rows[2]), .idx ('0), .bit_q (all_bit)
    );

    AST_SENSOR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rows[1] == rows[0] && row_addr[1] == row_addr[0] && sn_idx == rd_idx)
        |=> sn_bit == rd_bit); // R6

    AST_ALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (row_addr[2] == row_addr[0] && rd_idx == '0) |=> all_bit == rd_bit); // R7
endmodule

// File: tb/sim_profile_flag_mem.sv
module sim_profile_flag_mem;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_op = '0;
    logic [3:0]  rd_prof = '0, sn_prof = '0, all_prof = '0;
    logic [2:0]  rd_item = '0, all_item = '0;
    logic [4:0]  rd_idx = '0, sn_idx = '0;
    logic [1:0]  sn_cls = '0;
    logic        rd_bit, sn_bit, all_bit;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase = "R8 reset";

    bit mdl [16][8][32];
    bit exp_rd = 0, exp_sn = 0, exp_all = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    profile_flag_mem u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
        .rd_prof(rd_prof), .rd_item(rd_item), .rd_idx(rd_idx), .rd_bit(rd_bit),
        .sn_prof(sn_prof), .sn_cls(sn_cls), .sn_idx(sn_idx), .sn_bit(sn_bit),
        .all_prof(all_prof), .all_item(all_item), .all_bit(all_bit)
    );

    function automatic bit look(int p, int c, int x);
        return mdl[p][c][x] | mdl[p][c][0];
    endfunction

    // Reference model: predict from pre-edge state, then apply the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mdl[p, c, x]) mdl[p][c][x] = 0;
            exp_rd = 0; exp_sn = 0; exp_all = 0;
        end else begin
            exp_rd  = look(rd_prof, rd_item, rd_idx);
            exp_sn  = look(sn_prof, 4 + sn_cls, sn_idx);
            exp_all = mdl[all_prof][all_item][0];
            if (wr_en && wr_op[7:5] != 3)
                mdl[wr_op[11:8]][wr_op[7:5]][wr_op[4:0]] = 1;
        end
    end

    task automatic chk(string port, bit got, bit want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s %s got %0b exp %0b at %0t", phase, port, got, want, $time);
        end
    endtask

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk("rd_bit (R4 R5)", rd_bit, exp_rd);
            chk("sn_bit (R6)", sn_bit, exp_sn);
            chk("all_bit (R7)", all_bit, exp_all);
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int p, int c, int x);
        wr_en = 1; wr_op = {p[3:0], c[2:0], x[4:0]};
        step();
        wr_en = 0;
    endtask

    task automatic rd(int p, int c, int x);
        rd_prof = p[3:0]; rd_item = c[2:0]; rd_idx = x[4:0];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1;
        phase = "R1 R2 write";
        wr(2, 0, 7);
        rd(2, 0, 7); step(2);
        rd(2, 0, 6); step(2);
        phase = "R3 none class";
        wr(2, 3, 5);
        rd(2, 3, 5); all_prof = 2; all_item = 3; step(2);
        phase = "R9 same edge";
        rd(5, 4, 9); sn_prof = 5; sn_cls = 0; sn_idx = 9;
        wr(5, 4, 9);
        step(2);
        phase = "R5 all marker";
        wr(7, 1, 0);
        rd(7, 1, 13); all_prof = 7; all_item = 1; step(2);
        phase = "R6 sensor";
        wr(9, 6, 3);
        sn_prof = 9; sn_cls = 2; sn_idx = 3; step(2);
        sn_cls = 1; step(2);
        phase = "R1 R2 R5 R6 R7 random";
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom_range(0, 3) == 0);
            wr_op = {4'($urandom_range(0, 3)), 3'($urandom), 5'($urandom_range(0, 6))};
            rd(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)), int'($urandom_range(0, 6)));
            sn_prof = 4'($urandom_range(0, 3)); sn_cls = 2'($urandom); sn_idx = 5'($urandom_range(0, 6));
            all_prof = 4'($urandom_range(0, 3)); all_item = 3'($urandom);
            step();
        end
        wr_en = 0;
        phase = "R8 mid reset";
        rst_n = 0; step(2); rst_n = 1;
        rd(2, 0, 7); all_prof = 7; all_item = 1; sn_prof = 9; sn_cls = 2; sn_idx = 3;
        step(3);
        finish_run();
    end
endmodule